// File: doc/BRIEF.md
# Ground Key Debounce Filter

This block cleans up slowly changing detector inputs, such as a ground key or a second detect line, one input per line channel. Each cleaned bit then goes into a real-time status register, which is not part of this block. Each channel has a 4-bit period setting, counted in whole milliseconds. Software writes and reads the setting through a simple register port. A 1 ms strobe from an outside prescaler paces the filter.

A channel set to a nonzero period samples its synchronized input once per period. The output moves to a new level only when two samples in a row, one period apart, both show that level. A channel set to zero skips the filter, and its output tracks the synchronized input. Writing a period restarts that channel's sample timer and leaves its output as it is.

Top module: `gkey_filter`

## Requirements
- R1: Each channel has a 4-bit period register. A write with `wr_en` high stores `wr_data[3:0]` into channel `wr_ch`. Bits 7:4 of the written byte are discarded. `rd_data[3:0]` shows the period of channel `rd_ch` with no clock delay, and `rd_data[7:4]` always reads 0. A write or read that names a channel index of `NUM_CH` or above touches nothing, and such a read returns 0.
- R2: While `rst_n` is low, and after reset, every period register is 0 and every `filt_out` bit is 0.
- R3: Each `det_in` bit passes through two synchronizing flip-flops. With a period of 0, `filt_out` of that channel equals the value `det_in` had three rising clock edges earlier.
- R4: With a nonzero period P, a channel takes a sample on every P-th `ms_tick` pulse. The count starts over after reset, after any write to that channel, and from any clock in which the channel ran in bypass.
- R5: With a nonzero period, `filt_out` takes a new level only when the current sample and the sample just before it both show that level. A single sample that differs from the output changes nothing.
- R6: With a nonzero period, `filt_out` of a channel changes only on the rising edge at the end of a cycle in which that channel takes a sample, and a sample is taken only in a cycle where `ms_tick` is high.
- R7: A write to a channel leaves its `filt_out` unchanged on that edge. The write also clears the channel's sample history, so that two fresh samples are needed before the output can change.
- R8: Channels are independent. Writing to, or driving the input of, one channel has no effect on the output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| wr_en | input | 1 | Period register write strobe |
| wr_ch | input | CH_W | Channel index for writes |
| wr_data | input | DATA_W | Write byte; low PER_W bits are the period |
| rd_ch | input | CH_W | Channel index for reads |
| rd_data | output | DATA_W | Period of the addressed channel, upper bits 0 |
| det_in | input | NUM_CH | Raw asynchronous detector inputs |
| filt_out | output | NUM_CH | Filtered detector levels |

## Verification
The bench builds the block with `NUM_CH` = 3 and the default `PER_W` = 4. Three channels is not a power of two, so channel index 3 is a legal port value that addresses no channel. This is how R1's rule for out-of-range writes and reads gets checked. The bench raises `ms_tick` every fourth clock, so a period of 15 lasts only 60 cycles. This makes the longest sample spacing, and the repeated timer restarts from writes, short enough to run. Short periods of 1 to 3, mixed with random input glitches, exercise agreement between two samples in many phases against the behavioural model.

// File: rtl/gkf_pkg.sv
package gkf_pkg;

  typedef enum logic {
    GKF_BYPASS = 1'b0,
    GKF_FILTER = 1'b1
  } gkf_mode_e;

  // A period of zero selects the pass-through path.
  function automatic gkf_mode_e gkf_mode_of(input logic is_zero);
    return is_zero ? GKF_BYPASS : GKF_FILTER;
  endfunction

  // Two samples agree on a new level that differs from the present output.
  function automatic logic gkf_accept(input logic smp, input logic prev, input logic cur);
    return (smp == prev) && (smp != cur);
  endfunction

endpackage

// File: rtl/gkf_sync.sv
module gkf_sync #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] raw_in,
  output logic [NUM_CH-1:0] sync_out
);

  logic [NUM_CH-1:0] stage1_q;
  logic [NUM_CH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= raw_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gkf_period_regs.sv
module gkf_period_regs #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned PER_W  = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CH_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CH_W-1:0]         wr_ch,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [CH_W-1:0]         rd_ch,
  output logic [DATA_W-1:0]       rd_data,
  output logic [NUM_CH*PER_W-1:0] per_flat,
  output logic [NUM_CH-1:0]       restart
);

  logic [PER_W-1:0] per_q [NUM_CH];
  logic             unused_hi_bits;

  assign unused_hi_bits = ^wr_data[DATA_W-1:PER_W];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
    assign restart[c] = wr_en && (wr_ch == CH_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        per_q[c] <= '0;
      end else if (restart[c]) begin
        per_q[c] <= wr_data[PER_W-1:0];
      end
    end

    assign per_flat[c*PER_W +: PER_W] = per_q[c];
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_ch == CH_W'(c)) begin
        rd_data[PER_W-1:0] = per_q[c];
      end
    end
  end

endmodule

// File: rtl/gkf_chan.sv
module gkf_chan
  import gkf_pkg::*;
#(
  parameter int unsigned PER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sync_in,
  input  logic [PER_W-1:0] period,
  input  logic             restart,
  output logic             filt,
  output logic             sample_evt
);

  logic [PER_W-1:0] cnt_q;
  logic             prev_q;
  logic             filt_q;
  gkf_mode_e        mode;
  logic             due;

  // Last tick of the current period.
  function automatic logic period_end(input logic [PER_W-1:0] cnt,
                                      input logic [PER_W-1:0] per);
    return cnt == (per - PER_W'(1));
  endfunction

  assign mode       = gkf_mode_of(period == '0);
  assign due        = tick && period_end(cnt_q, period);
  assign sample_evt = (mode == GKF_FILTER) && !restart && due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
      filt_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      prev_q <= filt_q;
    end else if (mode == GKF_BYPASS) begin
      cnt_q  <= '0;
      prev_q <= sync_in;
      filt_q <= sync_in;
    end else if (tick) begin
      if (due) begin
        cnt_q  <= '0;
        prev_q <= sync_in;
        if (gkf_accept(sync_in, prev_q, filt_q)) begin
          filt_q <= sync_in;
        end
      end else begin
        cnt_q <= cnt_q + PER_W'(1);
      end
    end
  end

  assign filt = filt_q;

endmodule

// File: rtl/gkey_filter.sv
module gkey_filter #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned PER_W  = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) + 1 : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_CH-1:0] det_in,
  output logic [NUM_CH-1:0] filt_out
);

  logic [NUM_CH-1:0]       sync_w;
  logic [NUM_CH*PER_W-1:0] per_flat_w;
  logic [NUM_CH-1:0]       restart_w;
  logic [NUM_CH-1:0]       evt_w;

  gkf_sync #(.NUM_CH(NUM_CH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (det_in),
    .sync_out (sync_w)
  );

  gkf_period_regs #(
    .NUM_CH (NUM_CH),
    .PER_W  (PER_W),
    .DATA_W (DATA_W),
    .CH_W   (CH_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_ch    (wr_ch),
    .wr_data  (wr_data),
    .rd_ch    (rd_ch),
    .rd_data  (rd_data),
    .per_flat (per_flat_w),
    .restart  (restart_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    gkf_chan #(.PER_W(PER_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (ms_tick),
      .sync_in    (sync_w[c]),
      .period     (per_flat_w[c*PER_W +: PER_W]),
      .restart    (restart_w[c]),
      .filt       (filt_out[c]),
      .sample_evt (evt_w[c])
    );
  end

endmodule

// File: rtl/gkey_filter_chk.sv
module gkey_filter_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned PER_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ms_tick,
  input logic [DATA_W-1:0]       rd_data,
  input logic [NUM_CH-1:0]       filt_out,
  input logic [NUM_CH-1:0]       sync_w,
  input logic [NUM_CH*PER_W-1:0] per_flat_w,
  input logic [NUM_CH-1:0]       restart_w,
  input logic [NUM_CH-1:0]       evt_w
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:PER_W] == '0); // R1

  AST_RESET_OUT_LOW: assert property (@(posedge clk)
    !rst_n |-> (filt_out == '0)); // R2

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_BYPASS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (per_flat_w[c*PER_W +: PER_W] == '0 && !restart_w[c])
        |=> (filt_out[c] == $past(sync_w[c]))); // R3

    AST_SAMPLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      evt_w[c] |-> ms_tick); // R4

    AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (per_flat_w[c*PER_W +: PER_W] != '0 && !evt_w[c])
        |=> $stable(filt_out[c])); // R6

    AST_WRITE_KEEPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      restart_w[c] |=> $stable(filt_out[c])); // R7
  end

endmodule

bind gkey_filter gkey_filter_chk #(
  .NUM_CH (NUM_CH),
  .PER_W  (PER_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ms_tick    (ms_tick),
  .rd_data    (rd_data),
  .filt_out   (filt_out),
  .sync_w     (sync_w),
  .per_flat_w (per_flat_w),
  .restart_w  (restart_w),
  .evt_w      (evt_w)
);

// File: tb/gkey_filter_tb.sv
module gkey_filter_tb;

  localparam int NCH  = 3;
  localparam int CHW  = $clog2(NCH) + 1;
  localparam int TDIV = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           ms_tick = 1'b0;
  logic           wr_en = 1'b0;
  logic [CHW-1:0] wr_ch = '0;
  logic [7:0]     wr_data = '0;
  logic [CHW-1:0] rd_ch = '0;
  logic [7:0]     rd_data;
  logic [NCH-1:0] det_in = '0;
  logic [NCH-1:0] filt_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int tdiv = 0;
  string cur_req = "R2";
  bit done = 0;

  // Behavioural reference state, one entry per channel.
  int m_s1[NCH], m_s2[NCH], m_per[NCH], m_cnt[NCH], m_prev[NCH], m_out[NCH];

  gkey_filter #(.NUM_CH(NCH), .PER_W(4), .DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_data(wr_data), .rd_ch(rd_ch), .rd_data(rd_data), .det_in(det_in),
    .filt_out(filt_out)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // Millisecond strobe every TDIV clocks.
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TDIV;
    ms_tick <= (tdiv == TDIV - 1);
  end

  // Reference model, advanced on each rising edge.
  always @(posedge clk) begin
    cyc++;
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        m_s1[c] = 0; m_s2[c] = 0; m_per[c] = 0; m_cnt[c] = 0; m_prev[c] = 0; m_out[c] = 0;
      end else begin
        if (wr_en && int'(wr_ch) == c) begin
          m_cnt[c] = 0;
          m_prev[c] = m_out[c];
          m_per[c] = wr_data & 15;
        end else if (m_per[c] == 0) begin
          m_out[c] = m_s2[c];
          m_prev[c] = m_s2[c];
          m_cnt[c] = 0;
        end else if (ms_tick) begin
          m_cnt[c]++;
          if (m_cnt[c] == m_per[c]) begin
            m_cnt[c] = 0;
            if (m_s2[c] == m_prev[c]) m_out[c] = m_s2[c];
            m_prev[c] = m_s2[c];
          end
        end
        m_s2[c] = m_s1[c];
        m_s1[c] = int'(det_in[c]);
      end
    end
  end

  // Compare every output on every cycle.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NCH; c++) check(cur_req, int'(filt_out[c]), m_out[c]);
    end
  end

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic write_per(input int ch, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = CHW'(ch); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_per(input string req, input int ch, input int exp);
    @(negedge clk);
    rd_ch = CHW'(ch);
    #1;
    check(req, int'(rd_data), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    check("R2", int'(filt_out), 0);
    for (int c = 0; c < NCH; c++) read_per("R2", c, 0);

    // R3: bypass latency of three edges
    cur_req = "R3";
    @(negedge clk);
    det_in = 3'b001;
    @(negedge clk); check("R3", int'(filt_out[0]), 0);
    @(negedge clk); check("R3", int'(filt_out[0]), 0);
    @(negedge clk); check("R3", int'(filt_out[0]), 1);
    det_in = 3'b000;
    repeat (5) @(negedge clk);
    check("R3", int'(filt_out[0]), 0);

    // R1: write, read back, reserved bits, bad index
    cur_req = "R1";
    write_per(0, 8'hF2);
    write_per(1, 8'h51);
    write_per(2, 8'h0F);
    read_per("R1", 0, 2);
    read_per("R1", 1, 1);
    read_per("R1", 2, 15);
    write_per(3, 8'h07);
    read_per("R1", 0, 2);
    read_per("R1", 1, 1);
    read_per("R1", 2, 15);
    read_per("R1", 3, 0);

    // R5: steady high reaches the output on channel 1 after two samples
    cur_req = "R5";
    det_in[1] = 1'b1;
    repeat (20) @(negedge clk);
    check("R5", int'(filt_out[1]), 1);
    check("R8", int'(filt_out[0]), 0);

    // R7: repeated rewrites keep channel 2 from ever sampling
    cur_req = "R7";
    det_in[2] = 1'b1;
    for (int k = 0; k < 8; k++) begin
      repeat (28) @(negedge clk);
      write_per(2, 15);
    end
    check("R7", int'(filt_out[2]), 0);
    repeat (140) @(negedge clk);
    check("R4", int'(filt_out[2]), 1);

    // R8 / R4 / R6: random inputs and period changes on all channels
    cur_req = "R4 R5 R6 R8";
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if ($urandom_range(0, 9) == 0) det_in[$urandom_range(0, NCH - 1)] ^= 1'b1;
      if ($urandom_range(0, 299) == 0) begin
        wr_en = 1'b1;
        wr_ch = CHW'($urandom_range(0, NCH));
        wr_data = 8'($urandom_range(0, 3) | ($urandom_range(0, 15) << 4));
        @(negedge clk);
        wr_en = 1'b0;
      end
    end

    // R3: switch channel 1 to bypass mid-run
    cur_req = "R3";
    write_per(1, 0);
    det_in[1] = ~filt_out[1];
    repeat (4) @(negedge clk);
    check("R3", int'(filt_out[1]), int'(det_in[1]));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule